// File: doc/BRIEF.md
# Flash Command Sequencer with Data Polling

This block is the device-side command interpreter for a NOR-style flash that sits on a clocked bus. The bus is synchronous, like an SDRAM bus. On each clock the block samples chip select, a write strobe, a precharge indication, an address and a data byte. It recognises the keyed unlock sequences that open a word program or a sector erase.

When a sequence completes, the block starts a busy phase. A down-counter times this phase. Its length is a parameter in clock cycles, so a short value can stand in for the microseconds of a program or the seconds of an erase. While busy, the block ignores all bus writes. The status byte on `status_o` reports progress through bit 7, following the data-polling rules. Software polls that bit until it shows the final value.

Only the last programmed byte is kept. The block models no storage array.

Top module: `flash_cmd_poll`

## Requirements
- R1: A word program starts after four accepted writes in order: data AA at address 0x55, then 55 at 0x2A, then A0 at 0x55, then the data byte at any address. That last byte is latched as the programmed word.
- R2: A sector erase starts after six accepted writes in order: AA at 0x55, then 55 at 0x2A, then 80 at 0x55, then AA at 0x55, then 55 at 0x2A, then 30 at any address.
- R3: A cycle with `sel_i` and `pchg_i` both high is a no-operation, whatever `wen_i` holds. It neither advances nor resets a sequence in progress.
- R4: An accepted write that does not match the step expected next returns the sequencer to its start state and starts no operation. A cycle with `sel_i` low is not a bus cycle.
- R5: `busy_o` rises in the cycle after the final write of a program sequence. It stays high for exactly PROG_CYC cycles.
- R6: `busy_o` rises in the cycle after the final write of an erase sequence. It stays high for exactly ERASE_CYC cycles.
- R7: While `busy_o` is high, every write is ignored, including a complete command sequence. No operation is started or queued.
- R8: While a program is busy, `status_o` shows the programmed byte with bit 7 inverted. After the program completes, it shows the programmed byte unchanged.
- R9: While an erase is busy, `status_o` reads 0x00. After the erase completes, it reads 0xFF. After reset it reads 0xFF, with `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Chip select, active high |
| wen_i | input | 1 | Write strobe, active high |
| pchg_i | input | 1 | Precharge command marker, active high |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | 8 | Write data byte |
| status_o | output | 8 | Polling status byte |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench builds the block with PROG_CYC = 5 and ERASE_CYC = 12. With these values, a complete program or erase finishes within a few dozen cycles. The bench can therefore watch every busy window from its rising edge to its falling edge and check the status byte on both sides of each transition. The short windows also allow a full command sequence to be sent while the block is busy, and the test to wait for the phase to end.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] KEY_HI    = 8'hAA;
  localparam logic [7:0] KEY_LO    = 8'h55;
  localparam logic [7:0] OP_WORD   = 8'hA0;
  localparam logic [7:0] OP_ARM_ER = 8'h80;
  localparam logic [7:0] OP_SECTOR = 8'h30;
  localparam logic [7:0] LOC_HI    = 8'h55;
  localparam logic [7:0] LOC_LO    = 8'h2A;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_K1,
    SQ_K2,
    SQ_PDAT,
    SQ_E3,
    SQ_E4,
    SQ_E5
  } seq_t;

  typedef enum logic [1:0] {
    LAST_NONE,
    LAST_PROG,
    LAST_ERASE
  } last_op_t;

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wen_i,
  input  logic              pchg_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              go_prog_o,
  output logic              go_erase_o
);

  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(LOC_HI);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(LOC_LO);

  seq_t state_q, state_d;
  logic wr_acc;
  logic at_hi, at_lo;

  assign wr_acc = sel_i & wen_i & ~pchg_i & ~busy_i;
  assign at_hi  = (addr_i == A_HI);
  assign at_lo  = (addr_i == A_LO);

  always_comb begin
    state_d    = state_q;
    go_prog_o  = 1'b0;
    go_erase_o = 1'b0;
    if (wr_acc) begin
      state_d = SQ_IDLE;
      unique case (state_q)
        SQ_IDLE: if (at_hi && data_i == KEY_HI) state_d = SQ_K1;
        SQ_K1:   if (at_lo && data_i == KEY_LO) state_d = SQ_K2;
        SQ_K2: begin
          if (at_hi && data_i == OP_WORD)        state_d = SQ_PDAT;
          else if (at_hi && data_i == OP_ARM_ER) state_d = SQ_E3;
        end
        SQ_PDAT: go_prog_o = 1'b1;
        SQ_E3:   if (at_hi && data_i == KEY_HI) state_d = SQ_E4;
        SQ_E4:   if (at_lo && data_i == KEY_LO) state_d = SQ_E5;
        SQ_E5:   if (data_i == OP_SECTOR) go_erase_o = 1'b1;
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  // R3: a precharge slot leaves the sequence position untouched
  assert_pchg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && pchg_i) |=> $stable(state_q));

  // R7: nothing starts while an operation is running
  assert_no_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !(go_prog_o || go_erase_o));

  // R1 / R2: at most one kind of operation launched per cycle
  assert_one_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_prog_o && go_erase_o));

  // R2: an erase launch only comes from a real write slot
  assert_erase_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_erase_o |-> (sel_i && wen_i && !pchg_i));

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int PROG_CYC  = 15000,
  parameter int ERASE_CYC = 500000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_prog_i,
  input  logic go_erase_i,
  output logic busy_o
);

  localparam int CNT_W = $clog2(ERASE_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    cnt_en = 1'b0;
    if (busy_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (go_prog_i) begin
      cnt_en = 1'b1;
      busy_d = 1'b1;
      cnt_d  = PROG_LOAD;
    end else if (go_erase_i) begin
      cnt_en = 1'b1;
      busy_d = 1'b1;
      cnt_d  = ERASE_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

  // R5 / R6: busy follows a launch in the very next cycle
  assert_busy_after_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go_prog_i || go_erase_i) |=> busy_o);

  // R6: busy never appears without a launch before it
  assert_busy_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(go_prog_i || go_erase_i));

endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_prog_i,
  input  logic       go_erase_i,
  input  logic       busy_i,
  input  logic [7:0] data_i,
  output logic [7:0] status_o
);

  last_op_t   op_q, op_d;
  logic [7:0] word_q, word_d;
  logic       upd_en;

  always_comb begin
    op_d   = op_q;
    word_d = word_q;
    upd_en = 1'b0;
    if (go_prog_i) begin
      upd_en = 1'b1;
      op_d   = LAST_PROG;
      word_d = data_i;
    end else if (go_erase_i) begin
      upd_en = 1'b1;
      op_d   = LAST_ERASE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= LAST_NONE;
      word_q <= 8'hFF;
    end else if (upd_en) begin
      op_q   <= op_d;
      word_q <= word_d;
    end
  end

  always_comb begin
    unique case (op_q)
      LAST_PROG:  status_o = busy_i ? {~word_q[7], word_q[6:0]} : word_q;
      LAST_ERASE: status_o = busy_i ? 8'h00 : 8'hFF;
      default:    status_o = 8'hFF;
    endcase
  end

  // R8 / R9: the polled byte holds still during a running operation
  assert_status_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i)) |-> $stable(status_o));

  // R9: completion of an erase reads as all ones
  assert_erase_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_i) && op_q == LAST_ERASE) |-> status_o == 8'hFF);

endmodule

// File: rtl/flash_cmd_poll.sv
module flash_cmd_poll
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PROG_CYC  = 15000,
  parameter int ERASE_CYC = 500000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wen_i,
  input  logic              pchg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        status_o,
  output logic              busy_o
);

  logic go_prog, go_erase, busy;

  flash_seq_fsm #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel_i),
    .wen_i     (wen_i),
    .pchg_i    (pchg_i),
    .busy_i    (busy),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .go_prog_o (go_prog),
    .go_erase_o(go_erase)
  );

  flash_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_prog_i (go_prog),
    .go_erase_i(go_erase),
    .busy_o    (busy)
  );

  flash_status_mux u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_prog_i (go_prog),
    .go_erase_i(go_erase),
    .busy_i    (busy),
    .data_i    (data_i),
    .status_o  (status_o)
  );

  assign busy_o = busy;

  // R4: an unselected cycle never launches an operation
  assert_unsel_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> !$rose(busy_o));

endmodule

// File: tb/tb_flash_cmd_poll.sv
module tb_flash_cmd_poll;

  localparam int AW = 12;
  localparam int PC = 5;
  localparam int EC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wen = 1'b0, pchg = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] status;
  logic busy;

  always #2 clk = ~clk;

  flash_cmd_poll #(.ADDR_W(AW), .PROG_CYC(PC), .ERASE_CYC(EC)) dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .wen_i(wen), .pchg_i(pchg),
    .addr_i(addr), .data_i(din), .status_o(status), .busy_o(busy)
  );

  // behavioural reference
  int m_step;      // position in the keyed sequence, 0 = start
  bit m_erase_path;
  bit m_busy;
  int m_left;
  int m_op;        // 0 none, 1 program, 2 erase
  logic [7:0] m_word;
  int checks = 0, fails = 0, cycles = 0;
  string req = "R9";

  function automatic logic [7:0] m_status();
    if (m_op == 1) return m_busy ? (m_word ^ 8'h80) : m_word;
    if (m_op == 2) return m_busy ? 8'h00 : 8'hFF;
    return 8'hFF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_erase_path = 0; m_busy = 0; m_left = 0; m_op = 0; m_word = 8'hFF;
    end else if (m_busy) begin
      if (m_left == 0) m_busy = 0; else m_left = m_left - 1;
    end else if (sel && wen && !pchg) begin
      int nxt;
      nxt = 0;
      case (m_step)
        0: if (addr == 'h55 && din == 8'hAA) nxt = 1;
        1: if (addr == 'h2A && din == 8'h55) nxt = 2;
        2: if (addr == 'h55 && din == 8'hA0) begin nxt = 3; m_erase_path = 0; end
           else if (addr == 'h55 && din == 8'h80) begin nxt = 3; m_erase_path = 1; end
        3: if (!m_erase_path) begin
             m_busy = 1; m_left = PC - 1; m_op = 1; m_word = din;
           end else if (addr == 'h55 && din == 8'hAA) nxt = 4;
        4: if (addr == 'h2A && din == 8'h55) nxt = 5;
        5: if (din == 8'h30) begin m_busy = 1; m_left = EC - 1; m_op = 2; end
        default: nxt = 0;
      endcase
      m_step = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (busy !== m_busy || status !== m_status()) begin
        fails++;
        $display("FAIL %s: busy=%0b status=%02h expected busy=%0b status=%02h",
                 req, busy, status, m_busy, m_status());
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      sel = 0; wen = 0; pchg = 0;
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    sel = 1; wen = 1; pchg = 0; addr = a; din = d;
    @(negedge clk);
    sel = 0; wen = 0;
  endtask

  task automatic prechg(logic w);
    sel = 1; wen = w; pchg = 1; addr = 'h55; din = 8'hAA;
    @(negedge clk);
    sel = 0; wen = 0; pchg = 0;
  endtask

  task automatic prog(logic [AW-1:0] a, logic [7:0] d);
    wr('h55, 8'hAA); wr('h2A, 8'h55); wr('h55, 8'hA0); wr(a, d);
  endtask

  task automatic erase(logic [AW-1:0] s);
    wr('h55, 8'hAA); wr('h2A, 8'h55); wr('h55, 8'h80);
    wr('h55, 8'hAA); wr('h2A, 8'h55); wr(s, 8'h30);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R9"; idle(3);                        // reset state
    req = "R1"; prog('h300, 8'h96);             // R1 R5 R8 with bit7 set
    req = "R5"; idle(PC + 3);
    req = "R8"; prog('h055, 8'h15); idle(PC + 3);  // bit7 clear, target at 0x55
    req = "R2"; erase('h7C0);                   // R2 R6 R9
    req = "R6"; idle(EC + 3);
    req = "R3";                                 // precharge mid sequence
    wr('h55, 8'hAA); prechg(1); wr('h2A, 8'h55); prechg(0);
    wr('h55, 8'hA0); prechg(1); wr('h123, 8'h4C); idle(PC + 3);
    req = "R4";                                 // wrong address / data
    wr('h55, 8'hAA); wr('h2B, 8'h55); wr('h55, 8'hA0); wr('h10, 8'h00); idle(3);
    wr('h55, 8'hAA); wr('h2A, 8'h55); wr('h55, 8'h81); wr('h10, 8'h01); idle(3);
    wr('h55, 8'hAA); wr('h2A, 8'h55); wr('h55, 8'h80);
    wr('h55, 8'hAA); wr('h2A, 8'h55); wr('h20, 8'h31); idle(3);
    wr('h55, 8'hAA);                            // unselected write slot
    sel = 0; wen = 1; addr = 'h2A; din = 8'h55; @(negedge clk); wen = 0;
    wr('h55, 8'hA0); wr('h10, 8'h02); idle(3);
    req = "R7";                                 // commands while busy
    erase('h100); prog('h200, 8'h33); idle(EC + 3);
    prog('h210, 8'hC3); erase('h100); idle(EC + 3);
    req = "R1"; prog('h3FF, 8'h7E); idle(PC + 3);
    finish_run();
  end

endmodule